// File: doc/BRIEF.md
# Alternating Dual-Side Sonar Ranger

This block sequences a two-sided ultrasonic ranging cycle. Every ping period it pulses a trigger output that starts an external transmit burst. It holds both receive gates low around the burst. After a fixed dead time it opens the gate of one side only. It then times how long it takes for the shared, wired-OR echo line to rise. Successive pings serve the left side and then the right side, so one shared echo comparator output can serve two receivers.

The elapsed time from gate opening to the first synchronized rising edge of the echo is divided into bins of a parameterized width. The result is a 4-bit code that saturates at 15. A side that hears nothing during its window scores 15. When the right-side window closes, the block publishes one byte with the left code in bits 7:4 and the right code in bits 3:0, and raises a one-cycle strobe. All timing is given in clock cycles through parameters. The defaults give a 25 ms ping period and a 70 us dead time at 250 MHz.

Top module: `sonar_ranger`

## Requirements
- R1: After reset the first ping serves the left side. Pings then alternate strictly between left and right, and each ping opens only its own side's gate.
- R2: The trigger goes high for BURST_LEN cycles at the start of every ping. Its rising edges are exactly PING_PERIOD cycles apart. Both gates are low while the trigger is high and in the cycle just before it rises.
- R3: The active side's gate rises exactly DEAD_TIME cycles after the trigger rises.
- R4: The gates are never both high. An echo that occurs while the active gate is closed, including during the burst and dead time, has no effect on the result.
- R5: The distance code equals the cycles from gate opening to the synchronized echo edge divided by BIN_WIDTH, saturated at 15.
- R6: A side with no echo rising edge inside its window gets code 15. This includes an echo line that is already high when the gate opens and stays high.
- R7: The result byte holds {left code, right code} in bits [7:4] and [3:0]. It changes only at the end of a right-side window, together with a valid pulse exactly one cycle long.
- R8: Once an echo edge has been captured, the active gate falls on the next clock and stays low until the next ping.
- R9: While reset is high, the trigger, both gates and the valid strobe are low and the result byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| echo_in | input | 1 | Asynchronous shared echo comparator output, active high |
| burst_trig | output | 1 | High for BURST_LEN cycles at the start of each ping |
| gate_left | output | 1 | Left receive gate, high while listening |
| gate_right | output | 1 | Right receive gate, high while listening |
| range_byte | output | 8 | {left code, right code} |
| range_valid | output | 1 | One-cycle strobe when range_byte updates |

## Verification
The ranging path is driven with echo delays placed in the middle of a bin. These separate the codes 0, 1, 2, 3, 5 and 7 from their neighbours. Delays past the last bin show saturation, and pings with no echo show the empty-window code. Different left and right delays in the same pair show whether the nibbles are placed and ordered correctly. A pulse inside the burst followed by a real echo shows whether blanked edges leak through. An echo line held high across gate opening tells apart edge counting and level sensing. A mid-run reset shows that the side order restarts on the left.

// File: rtl/sonar_pkg.sv
package sonar_pkg;
  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
endpackage

// File: rtl/sonar_sync.sv
module sonar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sonar_sequencer.sv
module sonar_sequencer
  import sonar_pkg::*;
#(
  parameter int PING_PERIOD = 6_250_000,
  parameter int BURST_LEN   = 1000,
  parameter int DEAD_TIME   = 17_500
) (
  input  logic  clk,
  input  logic  rst,
  output side_e side,
  output logic  trig,
  output logic  arm,
  output logic  listen,
  output logic  gate_win,
  output logic  cyc_end
);
  localparam int CNT_W = $clog2(PING_PERIOD);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PING_PERIOD - 1);
  localparam logic [CNT_W-1:0] DEAD  = CNT_W'(DEAD_TIME);
  localparam logic [CNT_W-1:0] BURST = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] cnt;

  assign cyc_end  = (cnt == LAST);
  assign arm      = (cnt == DEAD);
  assign listen   = (cnt >= DEAD);
  assign gate_win = listen && !cyc_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      side <= SIDE_LEFT;
      trig <= 1'b0;
    end else begin
      trig <= (cnt < BURST);
      if (cyc_end) begin
        cnt  <= '0;
        side <= (side == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sonar_meter.sv
module sonar_meter
  import sonar_pkg::*;
#(
  parameter int BIN_WIDTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              listen,
  input  logic              rise,
  output logic              open_gate,
  output logic              hit,
  output logic [CODE_W-1:0] final_code
);
  localparam int BIN_W = (BIN_WIDTH > 1) ? $clog2(BIN_WIDTH) : 1;
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(BIN_WIDTH - 1);

  logic              done;
  logic [BIN_W-1:0]  bin_cnt;
  logic [CODE_W-1:0] run_code;
  logic [CODE_W-1:0] code_q;

  assign hit        = listen && !arm && !done && rise;
  assign open_gate  = arm || (listen && !done && !rise);
  assign final_code = done ? code_q : (hit ? run_code : CODE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b1;
      bin_cnt  <= '0;
      run_code <= '0;
      code_q   <= CODE_MAX;
    end else if (arm) begin
      done     <= 1'b0;
      bin_cnt  <= '0;
      run_code <= '0;
    end else if (listen && !done) begin
      if (rise) begin
        done   <= 1'b1;
        code_q <= run_code;
      end else if (bin_cnt == BIN_LAST) begin
        bin_cnt <= '0;
        if (run_code != CODE_MAX) run_code <= run_code + 1'b1;
      end else begin
        bin_cnt <= bin_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sonar_ranger.sv
module sonar_ranger
  import sonar_pkg::*;
#(
  parameter int PING_PERIOD = 6_250_000,
  parameter int BURST_LEN   = 1000,
  parameter int DEAD_TIME   = 17_500,
  parameter int BIN_WIDTH   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       echo_in,
  output logic       burst_trig,
  output logic       gate_left,
  output logic       gate_right,
  output logic [7:0] range_byte,
  output logic       range_valid
);
  side_e             side;
  logic              arm, listen, gate_win, cyc_end, rise;
  logic              open_gate, meas_hit;
  logic [CODE_W-1:0] final_code, left_q;

  sonar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(echo_in), .rise(rise)
  );

  sonar_sequencer #(
    .PING_PERIOD(PING_PERIOD), .BURST_LEN(BURST_LEN), .DEAD_TIME(DEAD_TIME)
  ) u_seq (
    .clk(clk), .rst(rst), .side(side), .trig(burst_trig), .arm(arm),
    .listen(listen), .gate_win(gate_win), .cyc_end(cyc_end)
  );

  sonar_meter #(.BIN_WIDTH(BIN_WIDTH)) u_meter (
    .clk(clk), .rst(rst), .arm(arm), .listen(listen), .rise(rise),
    .open_gate(open_gate), .hit(meas_hit), .final_code(final_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_left   <= 1'b0;
      gate_right  <= 1'b0;
      left_q      <= CODE_MAX;
      range_byte  <= {CODE_MAX, CODE_MAX};
      range_valid <= 1'b0;
    end else begin
      gate_left   <= gate_win && open_gate && (side == SIDE_LEFT);
      gate_right  <= gate_win && open_gate && (side == SIDE_RIGHT);
      range_valid <= cyc_end && (side == SIDE_RIGHT);
      if (cyc_end) begin
        if (side == SIDE_LEFT) left_q <= final_code;
        else                   range_byte <= {left_q, final_code};
      end
    end
  end
endmodule

// File: rtl/sonar_ranger_chk.sv
module sonar_ranger_chk (
  input logic       clk,
  input logic       rst,
  input logic       burst_trig,
  input logic       gate_left,
  input logic       gate_right,
  input logic [7:0] range_byte,
  input logic       range_valid,
  input logic       meas_hit
);
  logic expect_left;

  always_ff @(posedge clk) begin
    if (rst) expect_left <= 1'b1;
    else if (gate_left && !$past(gate_left))  expect_left <= 1'b0;
    else if (gate_right && !$past(gate_right)) expect_left <= 1'b1;
  end

  p_alt_left_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_left) |-> expect_left);
  p_alt_right_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_right) |-> !expect_left);
  p_blank_burst_r2: assert property (@(posedge clk) disable iff (rst)
    burst_trig |-> (!gate_left && !gate_right));
  p_gates_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(gate_left && gate_right));
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    range_valid |=> !range_valid);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !range_valid |-> $stable(range_byte));
  p_gate_drop_r8: assert property (@(posedge clk) disable iff (rst)
    meas_hit |=> (!gate_left && !gate_right));
endmodule

bind sonar_ranger sonar_ranger_chk u_chk (
  .clk(clk), .rst(rst), .burst_trig(burst_trig), .gate_left(gate_left),
  .gate_right(gate_right), .range_byte(range_byte),
  .range_valid(range_valid), .meas_hit(meas_hit)
);

// File: tb/sonar_ranger_tb.sv
module sonar_ranger_tb;
  localparam int PER   = 400;
  localparam int BURST = 16;
  localparam int DEAD  = 20;
  localparam int BIN   = 8;
  localparam int NV    = 6;
  localparam logic [7:0] NONE = 8'hFF;
  // left delay, right delay (cycles after gate seen), expected byte
  localparam logic [7:0] DL [NV] = '{8'd2,  8'd10,  8'd58,  8'd200, 8'hFF, 8'd34};
  localparam logic [7:0] DR [NV] = '{8'd2,  8'd26,  8'd122, 8'd42,  8'd18, 8'hFF};
  localparam logic [7:0] EX [NV] = '{8'h00, 8'h13,  8'h7F,  8'hF5,  8'hF2, 8'h4F};

  logic clk = 1'b0, rst = 1'b1, echo = 1'b0;
  logic trig, gl, gr, vld;
  logic [7:0] rb;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  sonar_ranger #(.PING_PERIOD(PER), .BURST_LEN(BURST), .DEAD_TIME(DEAD),
                 .BIN_WIDTH(BIN)) u_dut (
    .clk(clk), .rst(rst), .echo_in(echo), .burst_trig(trig),
    .gate_left(gl), .gate_right(gr), .range_byte(rb), .range_valid(vld));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_side(input bit right, input logic [7:0] d);
    do @(negedge clk); while (!(right ? gr : gl));
    check(!(gl && gr), "R4", {gl, gr}, right ? 1 : 2);
    if (d != NONE) begin
      repeat (int'(d)) @(negedge clk);
      echo = 1'b1;
      repeat (6) @(negedge clk);
      check(!gl && !gr, "R8", {gl, gr}, 0);
      echo = 1'b0;
    end
  endtask

  task automatic wait_valid(output logic [7:0] v);
    do @(negedge clk); while (!vld);
    v = rb;
    @(negedge clk);
    check(!vld, "R7", vld, 0);
  endtask

  initial begin
    logic [7:0] got;
    int cyc;
    bit blank_ok;
    repeat (3) @(negedge clk);
    check(!trig && !gl && !gr && !vld, "R9", {trig, gl, gr, vld}, 0);
    check(rb == 8'hFF, "R9", rb, 8'hFF);
    rst = 1'b0;

    // R2/R3 timing on the first ping pair, no echo
    do @(negedge clk); while (!trig);
    check(!gl && !gr, "R2", {gl, gr}, 0);
    cyc = 0; blank_ok = 1'b1;
    do begin
      @(negedge clk); cyc++;
      if (trig && (gl || gr)) blank_ok = 1'b0;
      if (gr) blank_ok = 1'b0;
    end while (!gl);
    check(blank_ok, "R2", blank_ok, 1);
    check(cyc == DEAD, "R3", cyc, DEAD);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!trig);
    check(cyc == PER - DEAD, "R2", cyc, PER - DEAD);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      check(!gl, "R1", gl, 0);
    end while (!gr);
    check(cyc == DEAD, "R3", cyc, DEAD);
    wait_valid(got);
    check(got == 8'hFF, "R6", got, 8'hFF);

    // table of delay pairs
    for (int i = 0; i < NV; i++) begin
      run_side(1'b0, DL[i]);
      run_side(1'b1, DR[i]);
      wait_valid(got);
      check(got == EX[i], "R5", got, EX[i]);
    end

    // R4: pulse during burst ignored; R6: echo high across gate opening
    do @(negedge clk); while (!trig);
    echo = 1'b1; repeat (4) @(negedge clk); echo = 1'b0;
    run_side(1'b0, 8'd18);
    do @(negedge clk); while (!trig);
    echo = 1'b1;
    do @(negedge clk); while (!gr);
    repeat (40) @(negedge clk);
    check(gr, "R6", gr, 1);
    wait_valid(got);
    echo = 1'b0;
    check(got == 8'h2F, "R4", got, 8'h2F);

    // mid-run reset: order restarts on the left
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!trig && !gl && !gr && !vld && rb == 8'hFF, "R9", {trig, gl, gr, vld, rb}, 0);
    rst = 1'b0;
    do @(negedge clk); while (!(gl || gr));
    check(gl && !gr, "R1", {gl, gr}, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule